// File: doc/BRIEF.md
# Frequency Synthesizer Configuration Register

This block is the software-visible control point for one frequency synthesizer. A simple single-cycle bus writes and reads three 32-bit words. The first holds the reference, feedback and output divider fields, the loop filter range and two bypass controls. The second holds a single output gate bit. The third is a read-only presence word, so that boot software can skip synthesizers that were not built into a given chip.

The analog loop is not modelled; only its lock is. Any write that changes a setting drops a read-only lock flag. The flag comes back after a settle interval whose length is a parameter. The block drives a clock-enable output that is high only while the synthesizer is locked and the gate bit is set. It also drives the decoded division and multiplication ratios for the clock-generation logic downstream.

Top module: `synth_cfg_reg`

## Requirements
- R1: After reset every configuration field reads zero, the gate bit is clear, `locked` is low and `clk_en` is low.
- R2: The configuration word at byte offset 0x0 is laid out as follows: reference divider in bits 5:0, feedback value in bits 14:6, output divider exponent in bits 17:15, filter range in bits 20:18, synthesizer bypass in bit 24, internal-feedback bypass in bit 25. Bits 23:21 and 30:26 read zero, and the fields change only when offset 0x0 is written.
- R3: Bit 31 of the configuration word reads the lock flag. Writes to that bit have no effect.
- R4: A write to offset 0x0 that changes any field makes `locked` low after that clock edge. `locked` goes high again exactly SETTLE_CYCLES edges after the write, and exactly SETTLE_CYCLES edges after reset is released.
- R5: A write to offset 0x0 whose fields equal the current ones leaves the lock flag and the settle count unchanged.
- R6: A changing write made while the settle count is running starts the count again from the full interval.
- R7: The gate word at offset 0x4 holds one bit at position GATE_BIT (31 by default). All its other bits read zero.
- R8: `clk_en` is high exactly when the gate bit is set and `locked` is high.
- R9: `ref_div` equals the reference field plus one. `fb_mult` equals twice the feedback field plus two. `out_div` equals two raised to the output exponent. `filt_range`, `pll_bypass` and `fb_bypass` follow their fields.
- R10: Offset 0x8 reads PRESENT_MASK in bits 5:0 and zero above. Writes to it have no effect.
- R11: Any other offset reads zero, and a write there changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| locked | output | 1 | Emulated lock indication |
| clk_en | output | 1 | Gated synthesizer clock enable |
| ref_div | output | 7 | Reference division ratio |
| fb_mult | output | 11 | Feedback multiplication ratio |
| out_div | output | 8 | Output division ratio |
| filt_range | output | 3 | Loop filter range |
| pll_bypass | output | 1 | Synthesizer bypass |
| fb_bypass | output | 1 | Internal-feedback bypass |

## Verification
The hardest case to reach is a write whose data has only bit 31 or the reserved bits set differently from the stored word. The bus must treat it as unchanged and must not restart the settle count. The stimulus reaches it by taking the model's current fields and setting random bits only in the ignored positions. Half of the random configuration writes are made this way. A second hard case is a changing write that lands in the middle of a settle interval. Directed steps write again a few cycles into the count, and the interval is kept short so that random writes often overlap one.

// File: rtl/synth_cfg_reg.sv
module synth_cfg_reg #(
  parameter int          SETTLE_CYCLES = 64,
  parameter logic [5:0]  PRESENT_MASK  = 6'b111111,
  parameter int          GATE_BIT      = 31,
  parameter int          ADDR_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              locked,
  output logic              clk_en,
  output logic [6:0]        ref_div,
  output logic [10:0]       fb_mult,
  output logic [7:0]        out_div,
  output logic [2:0]        filt_range,
  output logic              pll_bypass,
  output logic              fb_bypass
);

  localparam int          CNT_W    = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(SETTLE_CYCLES);
  localparam logic [25:0] FLD_MASK = 26'h31F_FFFF;
  localparam logic [ADDR_W-1:0] OFF_CFG  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_GATE = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_PRES = ADDR_W'(8);

  logic [5:0]       divr_q;
  logic [8:0]       divf_q;
  logic [2:0]       divq_q;
  logic [2:0]       range_q;
  logic             byp_q, fse_q, gate_q, lock_q;
  logic [CNT_W-1:0] cnt_q;

  logic [25:0] fld_now, fld_new;
  logic        cfg_wr, cfg_chg;
  logic        unused_wdata;

  assign fld_now = {fse_q, byp_q, 3'b000, range_q, divq_q, divf_q, divr_q};
  assign fld_new = bus_wdata[25:0] & FLD_MASK;
  assign cfg_wr  = bus_wr && (bus_addr == OFF_CFG);
  assign cfg_chg = cfg_wr && (fld_new != fld_now);
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divr_q  <= '0;
      divf_q  <= '0;
      divq_q  <= '0;
      range_q <= '0;
      byp_q   <= 1'b0;
      fse_q   <= 1'b0;
      lock_q  <= 1'b0;
      cnt_q   <= CNT_INIT;
    end else if (cfg_chg) begin
      divr_q  <= bus_wdata[5:0];
      divf_q  <= bus_wdata[14:6];
      divq_q  <= bus_wdata[17:15];
      range_q <= bus_wdata[20:18];
      byp_q   <= bus_wdata[24];
      fse_q   <= bus_wdata[25];
      lock_q  <= 1'b0;
      cnt_q   <= CNT_INIT;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else if (bus_wr && bus_addr == OFF_GATE) gate_q <= bus_wdata[GATE_BIT];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_CFG:  bus_rdata = {lock_q, 5'b00000, fld_now};
      OFF_GATE: bus_rdata[GATE_BIT] = gate_q;
      OFF_PRES: bus_rdata[5:0] = PRESENT_MASK;
      default:  bus_rdata = '0;
    endcase
  end

  assign locked     = lock_q;
  assign clk_en     = gate_q & lock_q;
  assign ref_div    = {1'b0, divr_q} + 7'd1;
  assign fb_mult    = {1'b0, divf_q, 1'b0} + 11'd2;
  assign out_div    = 8'd1 << divq_q;
  assign filt_range = range_q;
  assign pll_bypass = byp_q;
  assign fb_bypass  = fse_q;

  p_fields_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(fld_now));

  p_lock_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !locked);

  p_lock_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(cnt_q) == CNT_W'(1));

  p_same_keeps_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_chg && locked) |=> locked);

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_chg && cnt_q != '0) |=> cnt_q == CNT_INIT);

  p_gate_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> !clk_en);

endmodule

// File: tb/synth_cfg_reg_test.sv
`timescale 1ns/1ps
module synth_cfg_reg_test;
  localparam int N = 12;
  localparam logic [5:0] PRES = 6'b101101;
  localparam logic [25:0] MASK = 26'h31F_FFFF;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic locked, clk_en, pll_bypass, fb_bypass;
  logic [6:0] ref_div;
  logic [10:0] fb_mult;
  logic [7:0] out_div;
  logic [2:0] filt_range;

  always #2 clk = ~clk;

  synth_cfg_reg #(.SETTLE_CYCLES(N), .PRESENT_MASK(PRES), .GATE_BIT(31), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .locked(locked), .clk_en(clk_en),
    .ref_div(ref_div), .fb_mult(fb_mult), .out_div(out_div), .filt_range(filt_range),
    .pll_bypass(pll_bypass), .fb_bypass(fb_bypass));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [5:0] m_r = 0;
  logic [8:0] m_f = 0;
  logic [2:0] m_q = 0, m_rg = 0;
  logic m_b = 0, m_fs = 0, m_gate = 0;
  int since = 0;

  function automatic logic [25:0] mfields();
    return {m_fs, m_b, 3'b000, m_rg, m_q, m_f, m_r};
  endfunction

  function automatic logic mlock();
    return since >= N;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h00: return {mlock(), 5'b0, mfields()};
      8'h04: return {m_gate, 31'b0};
      8'h08: return {26'b0, PRES};
      default: return 32'b0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(logic [7:0] ra);
    string tag;
    bus_addr = ra;
    #0.5;
    case (ra)
      8'h00: tag = "R2 cfg read";
      8'h04: tag = "R7 gate read";
      8'h08: tag = "R10 presence read";
      default: tag = "R11 unmapped read";
    endcase
    chk(tag, bus_rdata, exp_read(ra));
    chk("R4 locked", {31'b0, locked}, {31'b0, mlock()});
    chk("R8 clk_en", {31'b0, clk_en}, {31'b0, m_gate & mlock()});
    chk("R9 ref_div", {25'b0, ref_div}, 32'(m_r) + 1);
    chk("R9 fb_mult", {21'b0, fb_mult}, 2 * (32'(m_f) + 1));
    chk("R9 out_div", {24'b0, out_div}, 32'd1 << m_q);
    chk("R9 range/bypass", {27'b0, filt_range, pll_bypass, fb_bypass}, {27'b0, m_rg, m_b, m_fs});
  endtask

  task automatic step(logic w, logic [7:0] a, logic [31:0] d, logic [7:0] ra);
    check_all(ra);
    bus_wr = w; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    if (w && a == 8'h00 && ((d[25:0] & MASK) != mfields())) begin
      m_r = d[5:0]; m_f = d[14:6]; m_q = d[17:15]; m_rg = d[20:18];
      m_b = d[24]; m_fs = d[25];
      since = 0;
    end else since++;
    if (w && a == 8'h04) m_gate = d[31];
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 8'(($urandom % 4) * 4));
  endtask

  localparam logic [31:0] CFG_A = {6'b000010, 3'b000, 3'd4, 3'd2, 9'd76, 6'd0};
  localparam logic [31:0] CFG_B = {6'b000011, 3'b000, 3'd4, 3'd5, 9'd39, 6'd1};

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    bus_addr = 8'h00; #0.5;
    chk("R1 cfg reset", bus_rdata, 32'h0);
    chk("R1 locked reset", {31'b0, locked}, 32'h0);
    chk("R1 clk_en reset", {31'b0, clk_en}, 32'h0);
    bus_addr = 8'h04; #0.5;
    chk("R1 gate reset", bus_rdata, 32'h0);
    @(negedge clk);
    rst_n = 1;
    idle(N + 3);
    chk("R4 lock after reset settle", {31'b0, locked}, 32'h1);

    step(1, 8'h00, CFG_A, 8'h00);
    chk("R4 lock dropped", {31'b0, locked}, 32'h0);
    idle(5);
    step(1, 8'h00, CFG_B, 8'h00);
    idle(N - 2);
    chk("R6 restarted count still low", {31'b0, locked}, 32'h0);
    idle(4);
    chk("R6 lock after restart", {31'b0, locked}, 32'h1);

    step(1, 8'h00, CFG_B | 32'h8000_0000, 8'h00);
    chk("R3 lock bit write ignored", {31'b0, locked}, 32'h1);
    step(1, 8'h00, CFG_B | 32'h7CE0_0000, 8'h00);
    chk("R5 same fields keep lock", {31'b0, locked}, 32'h1);

    step(1, 8'h04, 32'hFFFF_FFFF, 8'h04);
    bus_addr = 8'h04; #0.5;
    chk("R7 gate only bit 31", bus_rdata, 32'h8000_0000);
    chk("R8 enabled", {31'b0, clk_en}, 32'h1);
    step(1, 8'h00, CFG_A, 8'h00);
    chk("R8 gated by lock", {31'b0, clk_en}, 32'h0);
    step(1, 8'h08, 32'h0, 8'h08);
    bus_addr = 8'h08; #0.5;
    chk("R10 presence unchanged", bus_rdata, {26'b0, PRES});
    step(1, 8'h0C, 32'hFFFF_FFFF, 8'h0C);
    bus_addr = 8'h0C; #0.5;
    chk("R11 unmapped reads zero", bus_rdata, 32'h0);
    idle(N + 2);

    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [31:0] d;
      logic [7:0] ra;
      op = $urandom % 100;
      ra = 8'(($urandom % 5) * 4);
      if (op < 6) begin
        if ($urandom % 2) d = $urandom;
        else d = {6'b0, mfields()} | ($urandom & 32'hFCE0_0000);
        step(1, 8'h00, d, ra);
      end else if (op < 12) step(1, 8'h04, $urandom, ra);
      else if (op < 16) step(1, 8'(($urandom % 3) * 4 + 8), $urandom, ra);
      else step(0, 8'(($urandom % 4) * 4), $urandom, ra);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule